// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block watches the two wires of an I2C bus, clock (SCL) and data (SDA), without ever driving them. It turns what it sees into a stream of tagged event records. A fast system clock oversamples both lines. They pass through a synchroniser chain, and edges are found by comparing each synchronised sample with the one before it. The monitor sees each START, repeated START and STOP. It collects address and data bytes MSB first, tags each byte with its phase (address or data) and its direction (read or write), and reports whether the receiver acknowledged each byte.

Each event appears for one clock cycle on `ev_valid`, with a 4-bit code and an 8-bit payload. The monitor also counts transferred bits and elapsed system cycles from the latest START. When a STOP is seen it presents both counts, so downstream logic can work out the bit rate. A mode input chooses how the address byte is reported: either as the 7-bit address with the direction bit dropped, or as the raw 8-bit byte.

Top module: `i2c_bus_sniffer`

## Requirements
- R1: A synchronous active-high `rst` returns the monitor to the idle (find-START) phase with the direction unknown. While `rst` is high, and in the cycle after it, `ev_valid` is low. The first START after reset is reported with code 1.
- R2: In idle, SDA falling while SCL is high produces one event with code 1 (START) and payload 0. The monitor then starts collecting the address byte.
- R3: Bits are sampled on each SCL rising edge and shifted in MSB first. After the 8th bit of an address byte, an event is emitted. Its code is 6 (address-read) when bit 0 of the byte is 1, and 7 (address-write) when bit 0 is 0.
- R4: The address payload is the raw byte when `addr_raw_mode` is 1. When `addr_raw_mode` is 0 it is the byte shifted right by one with bit 7 cleared.
- R5: The SCL rising edge after each 8-bit byte samples the acknowledge bit. SDA low gives code 4 (ACK) and SDA high gives code 5 (NACK). In both cases the monitor goes on to the data phase.
- R6: In the data phase, each complete 8-bit byte is reported with its raw value as payload. The code is 8 (data-read) if the latest address byte had bit 0 set, and 9 (data-write) otherwise.
- R7: In the data phase, SDA falling while SCL is high produces code 2 (repeated START). The monitor then collects a new address byte.
- R8: In the data phase, SDA rising while SCL is high produces code 3 (STOP) and returns the monitor to idle. The next START is reported with code 1.
- R9: While an address byte or an acknowledge bit is being received, SDA edges during SCL high produce no event. Bit collection continues unchanged.
- R10: At STOP, `rate_valid` is high in the same cycle as the STOP event and at no other time. `rate_bits` counts the SCL rising edges sampled in the address and data phases since the latest START or repeated START; acknowledge bits are not counted, but the SCL rise just before the STOP is. `rate_cycles` is the number of system clock cycles from that START's SDA fall to the STOP's SDA rise.
- R11: Every event lasts one cycle. While `ev_valid` is low, `ev_code` and `ev_data` are 0. Codes 1 to 5 carry payload 0.
- R12: In idle, SCL edges and SDA rising while SCL is high produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| addr_raw_mode | input | 1 | 1: report address as raw byte; 0: 7-bit address |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_code | output | 4 | Event code (see requirements) |
| ev_data | output | 8 | Byte payload for codes 6 to 9 |
| rate_valid | output | 1 | Transfer counts valid, with STOP |
| rate_cycles | output | CYC_W (24) | System cycles from START to STOP |
| rate_bits | output | BIT_W (16) | Address and data bits since START |

## Verification
Internal state errors are visible within one byte. If the bit counter slips, the byte event shows up on the wrong SCL edge, with a shifted payload and a misplaced ACK code. A lost direction flag shows up on the very next data byte as the wrong code, 8 versus 9. A phase that does not return to idle shows at the next START, which is reported as code 2 instead of 1. Errors in the counters show only at STOP, in `rate_bits` and `rate_cycles`. The bench therefore ends each transfer with a STOP and checks both counts against its own cycle count, taken from the moments it drives the lines.

// File: rtl/i2c_sniff_pkg.sv
package i2c_sniff_pkg;

   localparam int BYTE_W = 8;
   localparam int CODE_W = 4;
   localparam int BIT_IDX_W = $clog2(BYTE_W);

   typedef enum logic [CODE_W-1:0] {
      EV_NONE    = 4'd0,
      EV_START   = 4'd1,
      EV_RSTART  = 4'd2,
      EV_STOP    = 4'd3,
      EV_ACK     = 4'd4,
      EV_NACK    = 4'd5,
      EV_ADDR_RD = 4'd6,
      EV_ADDR_WR = 4'd7,
      EV_DATA_RD = 4'd8,
      EV_DATA_WR = 4'd9
   } ev_code_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACK,
      PH_DATA
   } phase_e;

   typedef enum logic [1:0] {
      DIR_UNK,
      DIR_RD,
      DIR_WR
   } dir_e;

   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } line_t;

   function automatic logic [BYTE_W-1:0] fmt_addr(input logic [BYTE_W-1:0] b,
                                                  input logic raw);
      return raw ? b : {1'b0, b[BYTE_W-1:1]};
   endfunction

endpackage

// File: rtl/i2c_sniff_line_sync.sv
module i2c_sniff_line_sync
   import i2c_sniff_pkg::*;
#(
   parameter int   STAGES    = 2,
   parameter logic RESET_LVL = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  din,
   output line_t q
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_sniff_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= RESET_LVL;
               else     chain[gi] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= RESET_LVL;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev <= RESET_LVL;
      else     prev <= chain[LAST];
   end

   always_comb begin
      q.lvl  = chain[LAST];
      q.rise = chain[LAST] & ~prev;
      q.fall = ~chain[LAST] & prev;
   end

endmodule

// File: rtl/i2c_sniff_framer.sv
module i2c_sniff_framer
   import i2c_sniff_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  line_t             scl,
   input  line_t             sda,
   input  logic              addr_raw,
   output logic              ev_valid,
   output logic [CODE_W-1:0] ev_code,
   output logic [BYTE_W-1:0] ev_data,
   output logic              seg_start,
   output logic              seg_bit,
   output logic              seg_stop
);

   localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

   phase_e               phase;
   dir_e                 dir;
   logic                 rep_flag;
   logic [BYTE_W-1:0]    shreg;
   logic [BIT_IDX_W-1:0] bcnt;
   logic                 val_q;
   ev_code_e             code_q;
   logic [BYTE_W-1:0]    data_q;

   logic              start_cond;
   logic              stop_cond;
   logic [BYTE_W-1:0] nb;
   logic              byte_done;

   always_comb begin
      start_cond = scl.lvl & ~scl.rise & sda.fall;
      stop_cond  = scl.lvl & ~scl.rise & sda.rise;
      nb         = {shreg[BYTE_W-2:0], sda.lvl};
      byte_done  = (bcnt == LAST_BIT);
      seg_bit    = scl.rise & ((phase == PH_ADDR) | (phase == PH_DATA));
      seg_start  = start_cond & ((phase == PH_IDLE) | (phase == PH_DATA));
      seg_stop   = stop_cond & (phase == PH_DATA);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_IDLE;
         dir      <= DIR_UNK;
         rep_flag <= 1'b0;
         shreg    <= '0;
         bcnt     <= '0;
         val_q    <= 1'b0;
         code_q   <= EV_NONE;
         data_q   <= '0;
      end else begin
         val_q  <= 1'b0;
         code_q <= EV_NONE;
         data_q <= '0;
         unique case (phase)
            PH_IDLE: begin
               if (start_cond) begin
                  val_q    <= 1'b1;
                  code_q   <= rep_flag ? EV_RSTART : EV_START;
                  rep_flag <= 1'b1;
                  dir      <= DIR_UNK;
                  shreg    <= '0;
                  bcnt     <= '0;
                  phase    <= PH_ADDR;
               end
            end
            PH_ADDR: begin
               if (scl.rise) begin
                  shreg <= nb;
                  if (byte_done) begin
                     bcnt   <= '0;
                     dir    <= nb[0] ? DIR_RD : DIR_WR;
                     val_q  <= 1'b1;
                     code_q <= nb[0] ? EV_ADDR_RD : EV_ADDR_WR;
                     data_q <= fmt_addr(nb, addr_raw);
                     phase  <= PH_ACK;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
            end
            PH_ACK: begin
               if (scl.rise) begin
                  val_q  <= 1'b1;
                  code_q <= sda.lvl ? EV_NACK : EV_ACK;
                  phase  <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (scl.rise) begin
                  shreg <= nb;
                  if (byte_done) begin
                     bcnt   <= '0;
                     val_q  <= 1'b1;
                     code_q <= (dir == DIR_RD) ? EV_DATA_RD : EV_DATA_WR;
                     data_q <= nb;
                     phase  <= PH_ACK;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end else if (start_cond) begin
                  val_q    <= 1'b1;
                  code_q   <= rep_flag ? EV_RSTART : EV_START;
                  rep_flag <= 1'b1;
                  dir      <= DIR_UNK;
                  shreg    <= '0;
                  bcnt     <= '0;
                  phase    <= PH_ADDR;
               end else if (stop_cond) begin
                  val_q    <= 1'b1;
                  code_q   <= EV_STOP;
                  rep_flag <= 1'b0;
                  dir      <= DIR_UNK;
                  bcnt     <= '0;
                  phase    <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign ev_valid = val_q;
   assign ev_code  = code_q;
   assign ev_data  = data_q;

endmodule

// File: rtl/i2c_sniff_rate_meter.sv
module i2c_sniff_rate_meter #(
   parameter int CYC_W    = 24,
   parameter int BIT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             seg_start,
   input  logic             seg_bit,
   input  logic             seg_stop,
   output logic             rate_valid,
   output logic [CYC_W-1:0] rate_cycles,
   output logic [BIT_W-1:0] rate_bits
);

   localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);
   localparam logic [BIT_W-1:0] BIT_ONE = BIT_W'(1);

   generate
      if (CYC_W < 4) begin : g_bad_cyc
         $error("i2c_sniff_rate_meter: CYC_W must be at least 4");
      end
      if (BIT_W < 4) begin : g_bad_bit
         $error("i2c_sniff_rate_meter: BIT_W must be at least 4");
      end
   endgenerate

   logic [CYC_W-1:0] cyc_cnt;
   logic [CYC_W-1:0] cyc_inc;
   logic [BIT_W-1:0] bit_cnt;
   logic [BIT_W-1:0] bit_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cyc_inc = (&cyc_cnt) ? cyc_cnt : cyc_cnt + CYC_ONE;
         assign bit_inc = (&bit_cnt) ? bit_cnt : bit_cnt + BIT_ONE;
      end else begin : g_wrap
         assign cyc_inc = cyc_cnt + CYC_ONE;
         assign bit_inc = bit_cnt + BIT_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_cnt <= '0;
         bit_cnt <= '0;
      end else if (seg_start) begin
         cyc_cnt <= '0;
         bit_cnt <= '0;
      end else begin
         cyc_cnt <= cyc_inc;
         if (seg_bit) bit_cnt <= bit_inc;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_valid  <= 1'b0;
         rate_cycles <= '0;
         rate_bits   <= '0;
      end else begin
         rate_valid <= seg_stop;
         if (seg_stop) begin
            rate_cycles <= cyc_inc;
            rate_bits   <= bit_cnt;
         end
      end
   end

endmodule

// File: rtl/i2c_bus_sniffer.sv
module i2c_bus_sniffer
   import i2c_sniff_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CYC_W       = 24,
   parameter int BIT_W       = 16,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              addr_raw_mode,
   output logic              ev_valid,
   output logic [CODE_W-1:0] ev_code,
   output logic [BYTE_W-1:0] ev_data,
   output logic              rate_valid,
   output logic [CYC_W-1:0]  rate_cycles,
   output logic [BIT_W-1:0]  rate_bits
);

   localparam int N_LINES  = 2;
   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;

   logic [N_LINES-1:0] raw_lines;
   line_t              ln [N_LINES];
   logic               seg_start;
   logic               seg_bit;
   logic               seg_stop;

   assign raw_lines[LINE_SCL] = scl_in;
   assign raw_lines[LINE_SDA] = sda_in;

   generate
      for (genvar gl = 0; gl < N_LINES; gl++) begin : g_line
         i2c_sniff_line_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_LVL(1'b1)
         ) u_sync (
            .clk(clk),
            .rst(rst),
            .din(raw_lines[gl]),
            .q  (ln[gl])
         );
      end
   endgenerate

   i2c_sniff_framer u_framer (
      .clk      (clk),
      .rst      (rst),
      .scl      (ln[LINE_SCL]),
      .sda      (ln[LINE_SDA]),
      .addr_raw (addr_raw_mode),
      .ev_valid (ev_valid),
      .ev_code  (ev_code),
      .ev_data  (ev_data),
      .seg_start(seg_start),
      .seg_bit  (seg_bit),
      .seg_stop (seg_stop)
   );

   i2c_sniff_rate_meter #(
      .CYC_W   (CYC_W),
      .BIT_W   (BIT_W),
      .SATURATE(SATURATE)
   ) u_rate (
      .clk        (clk),
      .rst        (rst),
      .seg_start  (seg_start),
      .seg_bit    (seg_bit),
      .seg_stop   (seg_stop),
      .rate_valid (rate_valid),
      .rate_cycles(rate_cycles),
      .rate_bits  (rate_bits)
   );

endmodule

// File: rtl/i2c_bus_sniffer_chk.sv
module i2c_bus_sniffer_chk (
   input logic       clk,
   input logic       rst,
   input logic       addr_raw_mode,
   input logic       ev_valid,
   input logic [3:0] ev_code,
   input logic [7:0] ev_data,
   input logic       rate_valid
);

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !ev_valid); // R1

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
      ev_valid |-> (ev_code >= 4'd1 && ev_code <= 4'd9)); // R11

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !ev_valid |-> (ev_code == 4'd0 && ev_data == 8'd0)); // R11

   AST_NONBYTE_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_code <= 4'd5) |-> ev_data == 8'd0); // R11

   AST_ADDR_SHIFTED: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && (ev_code == 4'd6 || ev_code == 4'd7) && !addr_raw_mode)
         |-> !ev_data[7]); // R4

   AST_RATE_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
      rate_valid |-> (ev_valid && ev_code == 4'd3)); // R10

   AST_STOP_HAS_RATE: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_code == 4'd3) |-> rate_valid); // R10

endmodule

bind i2c_bus_sniffer i2c_bus_sniffer_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .addr_raw_mode(addr_raw_mode),
   .ev_valid     (ev_valid),
   .ev_code      (ev_code),
   .ev_data      (ev_data),
   .rate_valid   (rate_valid)
);

// File: tb/i2c_bus_sniffer_bench.sv
module i2c_bus_sniffer_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        scl, sda, raw;
   logic        ev_valid;
   logic [3:0]  ev_code;
   logic [7:0]  ev_data;
   logic        rate_valid;
   logic [23:0] rate_cycles;
   logic [15:0] rate_bits;

   always #5 clk = ~clk;

   i2c_bus_sniffer u_i2c_bus_sniffer (
      .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .addr_raw_mode(raw),
      .ev_valid(ev_valid), .ev_code(ev_code), .ev_data(ev_data),
      .rate_valid(rate_valid), .rate_cycles(rate_cycles), .rate_bits(rate_bits)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int H = 4;
   bit done = 1'b0;

   int rec_n = 0;
   int rec_code [0:1023];
   int rec_data [0:1023];
   int rec_rc   [0:1023];
   int rec_rb   [0:1023];
   int exp_n = 0;
   int exp_code [0:1023];
   int exp_data [0:1023];
   int exp_rc   [0:1023];
   int exp_rb   [0:1023];
   bit quiet_bad = 1'b0;
   bit rate_bad  = 1'b0;
   bit rst_bad   = 1'b0;

   int  start_cyc = 0;
   int  bits_seg  = 0;
   bit  dir_rd    = 1'b0;
   int  glitch_idx = -1;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst) begin
         if (ev_valid) rst_bad = 1'b1;
      end else begin
         if (ev_valid) begin
            if (rec_n < 1024) begin
               rec_code[rec_n] = int'(ev_code);
               rec_data[rec_n] = int'(ev_data);
               rec_rc[rec_n]   = int'(rate_cycles);
               rec_rb[rec_n]   = int'(rate_bits);
            end
            rec_n++;
            if ((ev_code == 4'd3) != rate_valid) rate_bad = 1'b1;
         end else begin
            if (ev_code != 4'd0 || ev_data != 8'd0) quiet_bad = 1'b1;
            if (rate_valid) rate_bad = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input int c, input int d, input int rc, input int rb);
      exp_code[exp_n] = c;
      exp_data[exp_n] = d;
      exp_rc[exp_n]   = rc;
      exp_rb[exp_n]   = rb;
      exp_n++;
   endtask

   task automatic do_start(input bit rep);
      if (rep) begin
         sda = 1'b1; tick(H);
         scl = 1'b1; tick(H);
      end
      sda = 1'b0;
      start_cyc = cyc;
      bits_seg  = 0;
      push(rep ? 2 : 1, 0, 0, 0);
      tick(H);
      scl = 1'b0; tick(H);
   endtask

   task automatic send_bit(input bit b, input bit glitch);
      sda = b; tick(H);
      scl = 1'b1; tick(H);
      if (glitch) begin
         sda = ~b; tick(H);
         sda = b;  tick(H);
      end
      scl = 1'b0; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit is_addr,
                            input bit ackb, input int gpos);
      for (int i = 7; i >= 0; i--) send_bit(b[i], (i == gpos));
      bits_seg += 8;
      if (is_addr) begin
         dir_rd = b[0];
         if (gpos >= 0) glitch_idx = exp_n;
         push(b[0] ? 6 : 7, raw ? int'(b) : int'(b >> 1), 0, 0);
      end else begin
         push(dir_rd ? 8 : 9, int'(b), 0, 0);
      end
      send_bit(ackb, 1'b0);
      push(ackb ? 5 : 4, 0, 0, 0);
   endtask

   task automatic do_stop();
      sda = 1'b0; tick(H);
      scl = 1'b1; tick(H);
      bits_seg++;
      sda = 1'b1;
      push(3, 0, cyc - start_cyc, bits_seg);
      tick(H);
   endtask

   function automatic string req_of(input int c);
      case (c)
         1: return "R2";
         2: return "R7";
         3: return "R8";
         4, 5: return "R5";
         6, 7: return "R3";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd2718);
      rst = 1'b1; scl = 1'b1; sda = 1'b1; raw = 1'b0;
      tick(6);
      chk(!ev_valid, "R1 reset valid", int'(ev_valid), 0);
      rst = 1'b0;
      tick(1);
      chk(!ev_valid, "R1 after reset", int'(ev_valid), 0);

      // R12: idle noise: SCL toggles and a stop-shaped SDA rise
      scl = 1'b0; tick(4);
      sda = 1'b0; tick(4);
      scl = 1'b1; tick(4);
      sda = 1'b1; tick(4);
      scl = 1'b0; tick(4);
      scl = 1'b1; tick(8);
      chk(rec_n == 0, "R12 idle no events", rec_n, 0);

      // directed transfer, shifted address, write
      raw = 1'b0; H = 4;
      do_start(1'b0);
      send_byte(8'hA2, 1'b1, 1'b0, -1);
      send_byte(8'h5A, 1'b0, 1'b0, -1);
      send_byte(8'h81, 1'b0, 1'b1, -1);
      do_stop();
      tick(6);
      chk(rec_n > 0 && rec_code[0] == 1, "R1 first start code", rec_code[0], 1);

      // raw address, read, glitch during address, repeated start to a write
      raw = 1'b1; H = 3;
      do_start(1'b0);
      send_byte(8'hA3, 1'b1, 1'b0, 4);
      send_byte(8'hFF, 1'b0, 1'b0, -1);
      do_start(1'b1);
      send_byte(8'h40, 1'b1, 1'b0, 0);
      send_byte(8'h00, 1'b0, 1'b1, -1);
      do_stop();
      tick(6);

      // constrained random transfers
      for (int t = 0; t < 24; t++) begin
         int nseg;
         raw = 1'($urandom_range(0, 1));
         H = $urandom_range(3, 6);
         nseg = $urandom_range(1, 2);
         for (int s = 0; s < nseg; s++) begin
            int nb;
            do_start(s != 0);
            send_byte(8'($urandom_range(0, 255)), 1'b1,
                      1'($urandom_range(0, 1)), -1);
            nb = $urandom_range(0, 3);
            for (int k = 0; k < nb; k++)
               send_byte(8'($urandom_range(0, 255)), 1'b0,
                         1'($urandom_range(0, 1)), -1);
         end
         do_stop();
         tick(5);
      end
      tick(10);

      chk(rec_n == exp_n, "R11 event count", rec_n, exp_n);
      for (int i = 0; i < exp_n && i < rec_n; i++) begin
         chk(rec_code[i] == exp_code[i], req_of(exp_code[i]), rec_code[i], exp_code[i]);
         if (exp_code[i] == 6 || exp_code[i] == 7)
            chk(rec_data[i] == exp_data[i], "R4 address payload", rec_data[i], exp_data[i]);
         else
            chk(rec_data[i] == exp_data[i], "R11 payload", rec_data[i], exp_data[i]);
         if (exp_code[i] == 3) begin
            chk(rec_rb[i] == exp_rb[i], "R10 bit count", rec_rb[i], exp_rb[i]);
            chk(rec_rc[i] == exp_rc[i], "R10 cycle count", rec_rc[i], exp_rc[i]);
         end
      end
      if (glitch_idx >= 0 && glitch_idx < rec_n)
         chk(rec_code[glitch_idx] == exp_code[glitch_idx] &&
             rec_data[glitch_idx] == exp_data[glitch_idx],
             "R9 glitch ignored", rec_data[glitch_idx], exp_data[glitch_idx]);
      chk(!quiet_bad, "R11 quiet outputs", int'(quiet_bad), 0);
      chk(!rate_bad, "R10 rate strobe", int'(rate_bad), 0);
      chk(!rst_bad, "R1 reset quiet", int'(rst_bad), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule